// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block performs one add, subtract or bitwise logic operation per clock on two operands. The operation works either on the low byte or on the whole word. It registers the result and keeps a 16-bit flag word. Six status bits in that word describe the last operation: carry, parity, half-carry, zero, sign and signed overflow. Three control bits (trap, interrupt enable and direction) are written only through a separate control write path. Arithmetic never touches them.

An execution stage presents operands, an operation code and a size select, then pulses `op_valid`. The result and the updated flags appear on the outputs after the next rising edge. Add-with-carry and subtract-with-borrow take their carry input from the stored carry flag. The unit can therefore chain byte or word operations into wider arithmetic.

Top module: `status_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first operation, `result` and `flags` are all zero.
- R2: With `op_valid` high at a rising edge, op code 0 (add) registers A+B and op code 1 (add with carry) registers A+B+CF, where CF is the stored carry flag. Flag bit 0 (carry) takes the carry out of the top bit of the selected size.
- R3: Op code 2 (subtract) registers A-B and op code 3 (subtract with borrow) registers A-B-CF. Flag bit 0 is set when the operation needed a borrow.
- R4: Flag bit 2 (parity) is 1 when the low 8 bits of the result hold an even number of ones, in both sizes.
- R5: Flag bit 4 (half-carry) is the carry from bit 3 into bit 4 on an add, or the borrow into bit 3 on a subtract.
- R6: Flag bit 6 (zero) is 1 exactly when the result is zero. Flag bit 7 (sign) copies bit 7 of the result in byte size and bit 15 in word size.
- R7: Flag bit 11 (overflow) is set when the signed add or subtract result does not fit the selected size. For example, byte 7Fh+01h gives 80h with carry 0, parity 0, half-carry 1, zero 0, sign 1 and overflow 1.
- R8: Op codes 4, 5 and 6 register A AND B, A OR B and A XOR B; op code 7 also performs XOR. All four clear carry, half-carry and overflow.
- R9: Trap, interrupt enable and direction sit at flag bits 8, 9 and 10. They load from `ctl_wdata` bits 0, 1 and 2 when `ctl_we` is high, and no operation changes them.
- R10: Flag bits 1, 3, 5, 12, 13, 14 and 15 always read 0, even when every control bit is written to 1.
- R11: With `size_word` low, the operation uses only the low 8 bits of each operand. The upper 8 bits of `result` are 0, and carry, sign, zero and overflow follow the byte result.
- R12: A rising edge with `op_valid` low leaves `result` and all six status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute the presented operation at this edge |
| op_sel | input | 3 | Operation code (0 add, 1 add-carry, 2 sub, 3 sub-borrow, 4 AND, 5 OR, 6/7 XOR) |
| size_word | input | 1 | 1 = word size, 0 = byte size |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| ctl_we | input | 1 | Load the three control flags |
| ctl_wdata | input | 3 | New control flags: bit 0 trap, bit 1 interrupt enable, bit 2 direction |
| result | output | 16 | Registered operation result |
| flags | output | 16 | Flag word |

## Verification
The bench targets carry and overflow at both size boundaries: 7Fh+01h in byte size, FFFFh+0001h in word size and 8000h-0001h. A design that took carry or sign from the wrong bit, or mixed up the overflow and carry rules, would report the wrong flags on these. Byte operations use operands with nonzero upper bytes, so a unit that leaked the high byte into the result or the zero flag shows up at once. Chained add-with-carry and subtract-with-borrow steps expose a unit that ignored the stored carry. Logic operations follow a carry-setting add, and control writes share a cycle with arithmetic. These catch flags that fail to clear, and control bits that arithmetic overwrites.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
   localparam int FLAG_W = 16;
   localparam int BYTE_W = 8;

   // flag bit positions within the flag word
   localparam int POS_CY = 0;
   localparam int POS_PA = 2;
   localparam int POS_HC = 4;
   localparam int POS_ZE = 6;
   localparam int POS_SG = 7;
   localparam int POS_TR = 8;
   localparam int POS_IE = 9;
   localparam int POS_DR = 10;
   localparam int POS_OV = 11;

   localparam logic [FLAG_W-1:0] STAT_MASK   = 16'h08D5;
   localparam logic [FLAG_W-1:0] UNUSED_MASK = 16'hF02A;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBB = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_XR2 = 3'd7
   } op_e;
endpackage

// File: rtl/flagu_parity.sv
module flagu_parity #(
   parameter int N = 8
) (
   input  logic [N-1:0] din,
   output logic         even
);
   logic [N:0] chain;
   assign chain[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_x
      assign chain[i+1] = chain[i] ^ din[i];
   end
   assign even = ~chain[N];
endmodule

// File: rtl/flagu_arith.sv
module flagu_arith
   import flagu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  op_e          op,
   input  logic         word,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cy,
   output logic         hc,
   output logic         ov
);
   localparam int UP_W = W - BYTE_W;

   logic [W-1:0] a_m, b_m, lg;
   logic [W:0]   ax, bx, sum, cx;
   logic         is_sub, is_arith, a_s, b_s, r_s;

   assign a_m = word ? a : {{UP_W{1'b0}}, a[BYTE_W-1:0]};
   assign b_m = word ? b : {{UP_W{1'b0}}, b[BYTE_W-1:0]};
   assign ax  = {1'b0, a_m};
   assign bx  = {1'b0, b_m};
   assign cx  = {{W{1'b0}}, ((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0};

   assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
   assign is_arith = ~op[2];

   assign sum = is_sub ? (ax - bx - cx) : (ax + bx + cx);

   always_comb begin
      unique case (op)
         OP_AND:  lg = a_m & b_m;
         OP_OR:   lg = a_m | b_m;
         default: lg = a_m ^ b_m;
      endcase
   end

   assign a_s = word ? a_m[W-1] : a_m[BYTE_W-1];
   assign b_s = word ? b_m[W-1] : b_m[BYTE_W-1];
   assign r_s = word ? sum[W-1] : sum[BYTE_W-1];

   assign res = is_arith ? (word ? sum[W-1:0] : {{UP_W{1'b0}}, sum[BYTE_W-1:0]}) : lg;
   assign cy  = is_arith & (word ? sum[W] : sum[BYTE_W]);
   assign hc  = is_arith & (ax[4] ^ bx[4] ^ sum[4]);
   assign ov  = is_arith & (r_s != a_s) & (is_sub ? (a_s != b_s) : (a_s == b_s));
endmodule

// File: rtl/flagu_ctl_reg.sv
module flagu_ctl_reg #(
   parameter int NCTL = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [NCTL-1:0] wdata,
   output logic [NCTL-1:0] q
);
   for (genvar i = 0; i < NCTL; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q[i] <= 1'b0;
         else if (we) q[i] <= wdata[i];
      end
   end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
   import flagu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_sel,
   input  logic             size_word,
   input  logic [W-1:0]     opnd_a,
   input  logic [W-1:0]     opnd_b,
   input  logic             ctl_we,
   input  logic [2:0]       ctl_wdata,
   output logic [W-1:0]     result,
   output logic [FLAG_W-1:0] flags
);
   if (W != 16) begin : g_bad_w
      $error("status_flag_unit: W must be 16 to match the flag layout");
   end

   logic [W-1:0] res_n;
   logic         cy_n, hc_n, ov_n, pa_n, ze_n, sg_n;
   logic         cy_q, pa_q, hc_q, ze_q, sg_q, ov_q;
   logic [2:0]   ctl_q;

   flagu_arith #(.W(W)) u_arith (
      .a(opnd_a), .b(opnd_b), .op(op_e'(op_sel)), .word(size_word),
      .cin(cy_q), .res(res_n), .cy(cy_n), .hc(hc_n), .ov(ov_n)
   );

   flagu_parity #(.N(BYTE_W)) u_par (
      .din(res_n[BYTE_W-1:0]), .even(pa_n)
   );

   flagu_ctl_reg #(.NCTL(3)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .q(ctl_q)
   );

   assign ze_n = (res_n == '0);
   assign sg_n = size_word ? res_n[W-1] : res_n[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         cy_q   <= 1'b0;
         pa_q   <= 1'b0;
         hc_q   <= 1'b0;
         ze_q   <= 1'b0;
         sg_q   <= 1'b0;
         ov_q   <= 1'b0;
      end else if (op_valid) begin
         result <= res_n;
         cy_q   <= cy_n;
         pa_q   <= pa_n;
         hc_q   <= hc_n;
         ze_q   <= ze_n;
         sg_q   <= sg_n;
         ov_q   <= ov_n;
      end
   end

   always_comb begin
      flags         = '0;
      flags[POS_CY] = cy_q;
      flags[POS_PA] = pa_q;
      flags[POS_HC] = hc_q;
      flags[POS_ZE] = ze_q;
      flags[POS_SG] = sg_q;
      flags[POS_TR] = ctl_q[0];
      flags[POS_IE] = ctl_q[1];
      flags[POS_DR] = ctl_q[2];
      flags[POS_OV] = ov_q;
   end
endmodule

// File: rtl/flagu_chk.sv
module flagu_chk
   import flagu_pkg::*;
#(
   parameter int W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_sel,
   input logic              size_word,
   input logic              ctl_we,
   input logic [W-1:0]      result,
   input logic [FLAG_W-1:0] flags
);
   assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & UNUSED_MASK) == '0);

   assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> flags[POS_DR:POS_TR] == $past(flags[POS_DR:POS_TR]));

   assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel[2]) |=> (!flags[POS_CY] && !flags[POS_OV] && !flags[POS_HC]));

   assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (flags[POS_ZE] == (result == '0)));

   assert_byte_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !size_word) |=> (result[W-1:BYTE_W] == '0));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(result) && ((flags & STAT_MASK) == ($past(flags) & STAT_MASK))));
endmodule

bind status_flag_unit flagu_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
   .size_word(size_word), .ctl_we(ctl_we), .result(result), .flags(flags)
);

// File: tb/sim_status_flag_unit.sv
`timescale 1ns/1ps
module sim_status_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic        size_word = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic        ctl_we = 1'b0;
   logic [2:0]  ctl_wdata = '0;
   logic [15:0] result, flags;

   int n_chk = 0, n_err = 0;

   // model state
   logic [15:0] m_res = '0;
   logic        m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
   logic [2:0]  m_ctl = '0;

   logic [15:0] q_res[$];
   logic [15:0] q_flg[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   status_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .result(result), .flags(flags)
   );

   function automatic logic [15:0] model_flags();
      logic [15:0] f = '0;
      f[0] = m_cf; f[2] = m_pf; f[4] = m_af; f[6] = m_zf; f[7] = m_sf;
      f[8] = m_ctl[0]; f[9] = m_ctl[1]; f[10] = m_ctl[2]; f[11] = m_of;
      return f;
   endfunction

   task automatic check(input logic [15:0] ar, af, er, ef, input string tag);
      n_chk++;
      if (ar !== er || af !== ef) begin
         n_err++;
         $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h", tag, ar, af, er, ef);
      end
   endtask

   // driver: one cycle of stimulus, pushes the expected state after the edge
   task automatic step(input bit v, input int op, input bit wd, input int a, input int b,
                       input bit cw, input int cd, input string tag);
      int mask, ua, ub, cin, full, sa, sb, sr, half, w;
      logic [15:0] r;
      @(negedge clk);
      op_valid = v; op_sel = op[2:0]; size_word = wd;
      opnd_a = a[15:0]; opnd_b = b[15:0]; ctl_we = cw; ctl_wdata = cd[2:0];
      if (v) begin
         w    = wd ? 16 : 8;
         mask = wd ? 32'hFFFF : 32'hFF;
         half = (mask + 1) / 2;
         ua = a & mask; ub = b & mask;
         sa = (ua >= half) ? ua - (mask + 1) : ua;
         sb = (ub >= half) ? ub - (mask + 1) : ub;
         cin = (op == 1 || op == 3) ? int'(m_cf) : 0;
         if (op < 2) begin
            full = ua + ub + cin;
            r = 16'(full & mask);
            m_cf = full > mask;
            m_af = ((ua & 15) + (ub & 15) + cin) > 15;
            sr = sa + sb + cin;
            m_of = (sr >= half) || (sr < -half);
         end else if (op < 4) begin
            full = ua - ub - cin;
            r = 16'(full & mask);
            m_cf = full < 0;
            m_af = (ua & 15) < ((ub & 15) + cin);
            sr = sa - sb - cin;
            m_of = (sr >= half) || (sr < -half);
         end else begin
            if (op == 4)      r = 16'(ua & ub);
            else if (op == 5) r = 16'(ua | ub);
            else              r = 16'(ua ^ ub);
            m_cf = 0; m_af = 0; m_of = 0;
         end
         m_res = r;
         m_zf = (r == 0);
         m_sf = r[w-1];
         m_pf = ($countones(r[7:0]) % 2) == 0;
      end
      if (cw) m_ctl = cd[2:0];
      q_res.push_back(m_res);
      q_flg.push_back(model_flags());
      q_tag.push_back(tag);
   endtask

   // monitor: compares outputs shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_res.size() > 0) begin
            logic [15:0] er, ef;
            string t;
            er = q_res.pop_front(); ef = q_flg.pop_front(); t = q_tag.pop_front();
            check(result, flags, er, ef, t);
         end
      end
   end

   initial begin
      #400000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: result=%h flags=%h expected completion", result, flags);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(result, flags, 16'h0, 16'h0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(result, flags, 16'h0, 16'h0, "R1 after reset");

      // byte boundary example
      step(1, 0, 0, 'h007F, 'h0001, 0, 0, "R7/R5/R4/R6 byte 7F+01");
      // word carry out and zero
      step(1, 0, 1, 'hFFFF, 'h0001, 0, 0, "R2/R6 word FFFF+1");
      // add with stored carry
      step(1, 1, 1, 'h0001, 'h0001, 0, 0, "R2 adc with CF=1");
      // byte borrow
      step(1, 2, 0, 'h0000, 'h0001, 0, 0, "R3/R5 byte 00-01");
      // subtract with stored borrow
      step(1, 3, 1, 'h0005, 'h0003, 0, 0, "R3 sbb with CF=1");
      // word signed overflow on subtract
      step(1, 2, 1, 'h8000, 'h0001, 0, 0, "R7 word 8000-1");
      // set carry then logic ops clear it
      step(1, 0, 1, 'h8000, 'h8000, 0, 0, "R7/R2 word 8000+8000");
      step(1, 4, 1, 'hF0F0, 'h0FF0, 0, 0, "R8 AND");
      step(1, 5, 0, 'h1230, 'h0005, 0, 0, "R8/R11 OR byte");
      step(1, 6, 1, 'hAAAA, 'hAAAA, 0, 0, "R8 XOR zero");
      step(1, 7, 1, 'h00FF, 'h0F0F, 0, 0, "R8 code 7 XOR");
      // byte op ignores high operand bytes
      step(1, 0, 0, 'h12FF, 'h3401, 0, 0, "R11 byte 12FF+3401");
      step(1, 2, 0, 'hAB80, 'hCD01, 0, 0, "R11/R7 byte 80-01");
      // control flags
      step(0, 0, 0, 0, 0, 1, 'b101, "R9 ctl write 101");
      step(1, 0, 1, 'h7FFF, 'h0001, 0, 0, "R9 arith keeps ctl");
      step(1, 2, 1, 'h0003, 'h0003, 1, 'b010, "R9 ctl and op same cycle");
      step(0, 0, 0, 0, 0, 1, 'b111, "R10 all ctl ones");
      // idle holds everything
      step(1, 0, 0, 'h00F0, 'h0090, 0, 0, "R2 byte carry set");
      step(0, 2, 1, 'h1234, 'h5678, 0, 0, "R12 idle hold");
      step(0, 4, 0, 'hFFFF, 'hFFFF, 0, 0, "R12 idle hold again");
      step(1, 1, 0, 'h0010, 'h0020, 0, 0, "R2 adc after idle");
      step(1, 3, 1, 'h0000, 'h0000, 0, 0, "R3/R4 sbb 0-0-0");
      step(0, 0, 0, 0, 0, 0, 0, "R12 final idle");

      @(negedge clk);
      op_valid = 1'b0; ctl_we = 1'b0;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule